// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a device: a serial test interface clocked by a dedicated test clock, steered by a mode-select line, with a serial data input, a tri-stated serial data output and an asynchronous active-low reset. A 16-state controller walks through the capture, shift and update phases of two scan paths. The instruction path holds a 4-bit opcode. The data path is one of three registers, picked by that opcode: a 1-bit bypass stage, a 32-bit identification word, or an external boundary chain.

The boundary chain lives outside the block. The block tells the chain when it is selected and gives it capture, shift and update strobes. The chain returns its serial output on `bnd_so`. Two further outputs go to the functional part of the device. One asks it to float all functional outputs. The other tells it that external-test mode is active. Reserved opcodes behave like bypass and leave the functional outputs alone. The test clock runs at up to 10 MHz and may be held low indefinitely.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The controller follows the standard 16-state transition graph on the rising edge of `tck`, sampling `tms`. From any state, five rising edges with `tms`=1 reach Test-Logic-Reset, and it stays there while `tms` stays 1.
- R2: While `trst_n` is low, the controller is held in Test-Logic-Reset at once, without a clock edge. In that reset the active opcode is 0010 (identification), `tdo_en`=0, `tdo` is high impedance, and `highz_req`, `extest_mode` and `bnd_sel` are 0.
- R3: Capture-IR loads the instruction shift stage with 1101, bit 0 first out. In Shift-IR the stage shifts right: `tdi` enters at bit 3 and bit 0 goes to `tdo`. Shifting out straight after capture gives 1,0,1,1.
- R4: The active opcode takes the shifted value on the falling edge of `tck` in Update-IR, not on the rising edge that enters that state. It becomes 0010 on the falling edge in Test-Logic-Reset.
- R5: Opcode decode works as follows. 0000 (external test) and 0001 (sample) select the boundary chain. 0010 selects the identification register. 0011 (float outputs) and 1111 select bypass. The reserved opcodes 0100 to 1110 also select bypass.
- R6: When selected, the identification register loads 32'h0042F067 in Capture-DR and shifts it out LSB first. The word is built, MSB to LSB, from version 0, part number 16'h042F, maker code 11'h033 and a fixed 1.
- R7: The bypass register loads 0 in Capture-DR. In Shift-DR it delays `tdi` by exactly one `tck`.
- R8: `highz_req` is 1 only while the active opcode is 0011. `extest_mode` is 1 only while it is 0000. Reserved opcodes drive both to 0.
- R9: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 only in Shift-IR and Shift-DR, and `tdo` is high impedance at all other times.
- R10: `bnd_sel` is 1 while the active opcode is 0000 or 0001. `bnd_capture`, `bnd_shift` and `bnd_update` are 1 only while `bnd_sel` is 1 and the controller is in Capture-DR, Shift-DR or Update-DR respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, high impedance when not shifting |
| tdo_en | output | 1 | Output enable for `tdo` |
| bnd_so | input | 1 | Serial output of the external boundary chain |
| bnd_sel | output | 1 | Boundary chain is the selected data path |
| bnd_capture | output | 1 | Boundary capture strobe (Capture-DR) |
| bnd_shift | output | 1 | Boundary shift strobe (Shift-DR) |
| bnd_update | output | 1 | Boundary update strobe (Update-DR) |
| highz_req | output | 1 | Request to float all functional outputs |
| extest_mode | output | 1 | External-test instruction is active |

## Verification
The hardest cases depend on which `tck` edge does the work. The active opcode and `tdo` both move on the falling edge, so a bench that samples only after full cycles cannot tell a falling-edge update from a rising-edge one. The stimulus therefore stops between the rising edge that enters Update-IR or Shift-DR and the next falling edge, and checks the old value there before checking the new one. The asynchronous reset is pulsed in the middle of a clock phase while the float-outputs instruction is active inside Shift-DR. The five-clock reset through `tms` is checked after four clocks and again after five.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDENT  = 4'b0010;
  localparam logic [IR_W-1:0] OP_FLOAT  = 4'b0011;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SCAN, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SCAN, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BND} dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     hiz;
    logic     ext;
  } instr_dec_t;

  // Next controller state for a given mode-select value.
  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    tap_state_e n;
    case (s)
      ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
      ST_IDLE:     n = m ? ST_DR_SCAN  : ST_IDLE;
      ST_DR_SCAN:  n = m ? ST_IR_SCAN  : ST_DR_CAP;
      ST_DR_CAP:   n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: n = m ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: n = m ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: n = m ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   n = m ? ST_DR_SCAN  : ST_IDLE;
      ST_IR_SCAN:  n = m ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: n = m ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: n = m ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: n = m ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     n = m ? ST_DR_SCAN  : ST_IDLE;
    endcase
    return n;
  endfunction

  // Opcode to data path and functional-side controls; unknown codes act as bypass.
  function automatic instr_dec_t instr_decode(logic [IR_W-1:0] op);
    instr_dec_t d;
    d.path = PATH_BYP;
    d.hiz  = 1'b0;
    d.ext  = 1'b0;
    if (op == OP_EXTEST) begin
      d.path = PATH_BND;
      d.ext  = 1'b1;
    end else if (op == OP_SAMPLE) begin
      d.path = PATH_BND;
    end else if (op == OP_IDENT) begin
      d.path = PATH_ID;
    end else if (op == OP_FLOAT) begin
      d.hiz  = 1'b1;
    end
    return d;
  endfunction

  // Identification word: version, part number, maker code, mandatory 1.
  function automatic logic [31:0] make_ident(logic [3:0] ver, logic [15:0] part, logic [10:0] maker);
    return {ver, part, maker, 1'b1};
  endfunction

endpackage

// File: rtl/tap_state_ctl.sv
module tap_state_ctl
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_RESET;
    else         state_q <= tap_next(state_q, tms);
  end

  assign state = state_q;

  assert_reset_hold_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_RESET && tms) |=> (state_q == ST_RESET));

  assert_shift_hold_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_DR_SHIFT && !tms) |=> (state_q == ST_DR_SHIFT));

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
  import scan_tap_pkg::*;
#(
  parameter int              W       = IR_W,
  parameter logic [W-1:0]    CAPTURE = 4'b1101,
  parameter logic [W-1:0]    RST_OP  = OP_IDENT
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  tap_state_e   state,
  output logic         ir_so,
  output logic [W-1:0] active_op
);

  logic [W-1:0] shift_q;
  logic [W-1:0] op_q;
  logic         cap_w, sh_w, upd_w, rst_w;

  assign cap_w = (state == ST_IR_CAP);
  assign sh_w  = (state == ST_IR_SHIFT);
  assign upd_w = (state == ST_IR_UPD);
  assign rst_w = (state == ST_RESET);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    shift_q <= CAPTURE;
    else if (cap_w) shift_q <= CAPTURE;
    else if (sh_w)  shift_q <= {tdi, shift_q[W-1:1]};
  end

  // Active opcode moves on the falling edge only.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)    op_q <= RST_OP;
    else if (rst_w) op_q <= RST_OP;
    else if (upd_w) op_q <= shift_q;
  end

  assign ir_so     = shift_q[0];
  assign active_op = op_q;

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!trst_n)
    cap_w |=> (shift_q == CAPTURE));

  assert_op_stable_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_w && !rst_w) |-> $stable(op_q));

endmodule

// File: rtl/tap_data_regs.sv
module tap_data_regs
  import scan_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0042F067
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  dr_path_e   path,
  input  logic       ir_so,
  input  logic       bnd_so,
  output logic       tdo_bit,
  output logic       tdo_en
);

  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic            cap_w, shdr_w, shir_w, dr_so_w;
  logic            tdo_q, en_q;

  assign cap_w  = (state == ST_DR_CAP);
  assign shdr_w = (state == ST_DR_SHIFT);
  assign shir_w = (state == ST_IR_SHIFT);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
    end else if (cap_w) begin
      byp_q <= 1'b0;
      if (path == PATH_ID) id_q <= ID_VALUE;
    end else if (shdr_w) begin
      if (path == PATH_BYP) byp_q <= tdi;
      if (path == PATH_ID)  id_q  <= {tdi, id_q[ID_W-1:1]};
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_so_w = id_q[0];
      PATH_BND: dr_so_w = bnd_so;
      default:  dr_so_w = byp_q;
    endcase
  end

  // Serial output retimed to the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      tdo_q <= shir_w ? ir_so : dr_so_w;
      en_q  <= shir_w | shdr_w;
    end
  end

  assign tdo_bit = tdo_q;
  assign tdo_en  = en_q;

  assert_byp_capture_R7: assert property (@(posedge tck) disable iff (!trst_n)
    cap_w |=> (byp_q == 1'b0));

  assert_id_capture_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_w && path == PATH_ID) |=> (id_q == ID_VALUE));

  assert_tdo_window_R9: assert property (@(posedge tck) disable iff (!trst_n)
    en_q |-> (shir_w || shdr_w));

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [15:0] ID_PART    = 16'h042F,
  parameter logic [10:0] ID_MAKER   = 11'h033,
  parameter logic [3:0]  IR_CAPTURE = 4'b1101
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  input  logic bnd_so,
  output logic bnd_sel,
  output logic bnd_capture,
  output logic bnd_shift,
  output logic bnd_update,
  output logic highz_req,
  output logic extest_mode
);

  localparam logic [31:0] ID_WORD = make_ident(ID_VERSION, ID_PART, ID_MAKER);

  tap_state_e       state;
  logic [IR_W-1:0]  active_op;
  logic             ir_so;
  logic             tdo_bit;
  instr_dec_t       dec;

  tap_state_ctl u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  tap_instr_reg #(.W(IR_W), .CAPTURE(IR_CAPTURE), .RST_OP(OP_IDENT)) u_ir (
    .tck       (tck),
    .trst_n    (trst_n),
    .tdi       (tdi),
    .state     (state),
    .ir_so     (ir_so),
    .active_op (active_op)
  );

  assign dec = instr_decode(active_op);

  tap_data_regs #(.ID_W(32), .ID_VALUE(ID_WORD)) u_dr (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .state   (state),
    .path    (dec.path),
    .ir_so   (ir_so),
    .bnd_so  (bnd_so),
    .tdo_bit (tdo_bit),
    .tdo_en  (tdo_en)
  );

  assign bnd_sel     = (dec.path == PATH_BND);
  assign bnd_capture = bnd_sel && (state == ST_DR_CAP);
  assign bnd_shift   = bnd_sel && (state == ST_DR_SHIFT);
  assign bnd_update  = bnd_sel && (state == ST_DR_UPD);
  assign highz_req   = dec.hiz;
  assign extest_mode = dec.ext;
  assign tdo         = tdo_en ? tdo_bit : 1'bz;

  assert_hiz_change_R8: assert property (@(posedge tck) disable iff (!trst_n)
    $changed(highz_req) |-> (state == ST_IR_UPD || state == ST_RESET));

  assert_bnd_quiet_R10: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_IDLE) |-> !(bnd_capture || bnd_shift || bnd_update));

endmodule

// File: tb/scan_tap_ctrl_test.sv
`timescale 1ns/100ps
module scan_tap_ctrl_test;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms_r = 1'b1;
  logic tdi_r = 1'b0;
  logic tdo, tdo_en, bnd_so, bnd_sel, bnd_capture, bnd_shift, bnd_update, highz_req, extest_mode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [31:0] ID_EXP = 32'h0042F067;
  localparam logic [7:0]  BND_CAP = 8'hA5;

  // {opcode, path kind (0 bypass, 1 id, 2 boundary), highz, extest}
  localparam logic [7:0] VEC [16] = '{
    {4'd0,  2'd2, 1'b0, 1'b1}, {4'd1,  2'd2, 1'b0, 1'b0},
    {4'd2,  2'd1, 1'b0, 1'b0}, {4'd3,  2'd0, 1'b1, 1'b0},
    {4'd4,  2'd0, 1'b0, 1'b0}, {4'd5,  2'd0, 1'b0, 1'b0},
    {4'd6,  2'd0, 1'b0, 1'b0}, {4'd7,  2'd0, 1'b0, 1'b0},
    {4'd8,  2'd0, 1'b0, 1'b0}, {4'd9,  2'd0, 1'b0, 1'b0},
    {4'd10, 2'd0, 1'b0, 1'b0}, {4'd11, 2'd0, 1'b0, 1'b0},
    {4'd12, 2'd0, 1'b0, 1'b0}, {4'd13, 2'd0, 1'b0, 1'b0},
    {4'd14, 2'd0, 1'b0, 1'b0}, {4'd15, 2'd0, 1'b0, 1'b0}
  };

  scan_tap_ctrl uut (
    .tck(tck), .trst_n(trst_n), .tms(tms_r), .tdi(tdi_r), .tdo(tdo), .tdo_en(tdo_en),
    .bnd_so(bnd_so), .bnd_sel(bnd_sel), .bnd_capture(bnd_capture), .bnd_shift(bnd_shift),
    .bnd_update(bnd_update), .highz_req(highz_req), .extest_mode(extest_mode)
  );

  always #2 tck = ~tck;

  // Bench model of an 8-cell external boundary chain.
  logic [7:0] chain = 8'h00;
  always @(posedge tck) begin
    if (bnd_capture)    chain <= BND_CAP;
    else if (bnd_shift) chain <= {tdi_r, chain[7:1]};
  end
  assign bnd_so = chain[0];

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge tck) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic m, logic d);
    tms_r = m;
    tdi_r = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic ir_to_exit(logic [3:0] op, output logic [3:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = tdo;
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i]);
      if (i < 3) cap[i+1] = tdo;
    end
  endtask

  task automatic load_ir(logic [3:0] op, output logic [3:0] cap);
    ir_to_exit(op, cap);
    step(1, 0);
    step(0, 0);
  endtask

  task automatic shift_dr(logic [31:0] din, output logic [31:0] dout, output logic upd);
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = tdo;
    for (int i = 0; i < 32; i++) begin
      step(i == 31, din[i]);
      if (i < 31) dout[i+1] = tdo;
    end
    step(1, 0);
    upd = bnd_update;
    step(0, 0);
  endtask

  initial begin
    logic [3:0]  cap;
    logic [31:0] dout;
    logic [31:0] expd;
    logic        upd;

    // R2: reset state while trst_n is low
    #5;
    chk("R2 tdo_en in reset", tdo_en, 0);
    chk("R2 tdo floats", {31'd0, tdo === 1'bz}, 1);
    chk("R2 highz_req", highz_req, 0);
    chk("R2 extest_mode", extest_mode, 0);
    chk("R2 bnd_sel", bnd_sel, 0);
    @(negedge tck);
    trst_n = 1'b1;
    step(0, 0);
    chk("R9 tdo_en idle", tdo_en, 0);

    // R4 R6: identification selected after reset without any IR load
    shift_dr(32'hFFFF_FFFF, dout, upd);
    chk("R6 default ident read", dout, ID_EXP);

    // Table walk over all opcodes: R3 R5 R7 R8 R10
    for (int v = 0; v < 16; v++) begin
      logic [3:0]  op;
      logic [1:0]  kind;
      logic [31:0] pat;
      op   = VEC[v][7:4];
      kind = VEC[v][3:2];
      pat  = 32'hC3A5_5A3C ^ {8{op}};
      load_ir(op, cap);
      chk("R3 IR capture 1101", cap, 4'b1101);
      chk("R8 highz_req", highz_req, VEC[v][1]);
      chk("R8 extest_mode", extest_mode, VEC[v][0]);
      chk("R10 bnd_sel", bnd_sel, kind == 2);
      shift_dr(pat, dout, upd);
      if (kind == 0)      expd = {pat[30:0], 1'b0};
      else if (kind == 1) expd = ID_EXP;
      else                expd = {pat[23:0], BND_CAP};
      chk("R5 R7 data path output", dout, expd);
      chk("R10 bnd_update strobe", upd, kind == 2);
      chk("R8 hold after DR scan", highz_req, VEC[v][1]);
    end

    // R4: opcode changes on the falling edge in Update-IR
    load_ir(4'b1111, cap);
    ir_to_exit(4'b0011, cap);
    tms_r = 1'b1;
    @(posedge tck);
    #0.5;
    chk("R4 before falling edge", highz_req, 0);
    @(negedge tck);
    #1;
    chk("R4 after falling edge", highz_req, 1);
    step(0, 0);

    // R9: tdo_en rises only on the falling edge in Shift-DR
    step(1, 0); step(0, 0);
    tms_r = 1'b0;
    tdi_r = 1'b1;
    @(posedge tck);
    #0.5;
    chk("R9 tdo_en before falling edge", tdo_en, 0);
    @(negedge tck);
    #1;
    chk("R9 tdo_en in shift", tdo_en, 1);
    chk("R7 bypass captured 0", tdo, 0);

    // R2: asynchronous reset in the middle of a phase
    #0.7;
    trst_n = 1'b0;
    #0.2;
    chk("R2 async highz_req drop", highz_req, 0);
    chk("R2 async tdo_en drop", tdo_en, 0);
    @(negedge tck);
    trst_n = 1'b1;
    step(0, 0);

    // R1: five clocks with tms high reach reset from Shift-DR
    load_ir(4'b0011, cap);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 4; k++) step(1, 0);
    chk("R1 four clocks not reset", highz_req, 1);
    step(1, 0);
    chk("R1 five clocks reset", highz_req, 0);
    step(1, 0);
    chk("R1 reset hold", highz_req, 0);
    step(0, 0);
    chk("R9 tdo floats idle", {31'd0, tdo === 1'bz}, 1);
    shift_dr(32'h0, dout, upd);
    chk("R4 ident after tms reset", dout, ID_EXP);

    summary();
  end

endmodule